// File: doc/BRIEF.md
# Synchronous External Bus Slave Port

This block lets an outside bus master read and write a small on-chip word memory over a synchronous address/data bus. The master places an address on the bus together with a read or a write strobe for one cycle, the address phase. The slave latches the transfer and then runs one or more data beats. During each beat it holds the acknowledge line low for a configurable number of wait cycles. A beat completes in the first data-phase cycle where acknowledge is high. Read data is valid on the data bus in that cycle, and write data is sampled at the end of it.

When the burst line is high, the slave keeps only the first address of the transfer. After each completed beat it steps an internal word counter, so the master can stream consecutive words without driving new addresses. The slave watches the burst line in each completing beat. When the line is low the transfer ends after that beat, and the next strobe latches a new address. Alongside the transfer logic, the top address bits are decoded into two memory-bank selects and a host-space select. These selects follow the address and strobes in the same cycle.

Only one address window maps to the internal memory: the window whose top five bits equal the local tag, zero by default. Accesses that decode to any other window complete without wait states. They never change the memory, and reads from them return zero.

Top module: `ebs_slave`

## Requirements
- R1: After reset, acknowledge is high, all three selects are low and the read data bus is zero.
- R2: Select outputs are combinational. Bank-0 select is high when a strobe is active and address bits 31:27 are 5'b00110. Bank-1 select is high when a strobe is active and bits 31:27 are 5'b00111. Host select is high when a strobe is active and bit 31 is 1. At most one select is high at any time.
- R3: For an access to the internal window (bits 31:27 equal 5'b00000), acknowledge stays low for exactly W cycles after the address phase, where W is wait_cfg (0 to 3). It is then high for the completing cycle.
- R4: A read returns the memory word indexed by address bits 7:0. The word appears on bus_rdata in the cycle acknowledge is high and completes the beat. Outside a completing beat, bus_rdata is zero.
- R5: A write stores bus_wdata into the indexed word at the end of the completing cycle. If both strobes are active, the access is a read.
- R6: When bus_burst is high in a completing cycle, the slave ignores bus_addr and advances its word index by one for the next beat. The index wraps from 255 to 0.
- R7: The wait count is reloaded from wait_cfg for every beat of a burst.
- R8: When bus_burst is low in a completing cycle, the transfer ends after that beat. Strobes and addresses presented during the data phase are ignored. The next strobe in the idle state latches a fresh address.
- R9: An access outside the internal window gets no wait states and leaves the memory unchanged. A read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Address from the master |
| bus_rd | input | 1 | Read strobe, valid with the address |
| bus_wr | input | 1 | Write strobe, valid with the address |
| bus_burst | input | 1 | High while further consecutive beats follow |
| bus_wdata | input | 32 | Write data from the master |
| wait_cfg | input | 2 | Wait cycles inserted before each beat |
| bus_rdata | output | 32 | Read data, valid in the completing cycle |
| bus_ack | output | 1 | Low while the slave inserts wait states |
| sel_bank0 | output | 1 | Memory bank 0 select |
| sel_bank1 | output | 1 | Memory bank 1 select |
| sel_host | output | 1 | Host address space select |

## Verification
The assertions check the following on every cycle:
- the select outputs are mutually exclusive and active only with a strobe;
- acknowledge is low only in a wait state;
- a wait-configured local access or burst beat drops acknowledge in the following cycle, and an out-of-window access never does;
- the word index advances by exactly one per burst beat and is held in between;
- a beat without burst returns the slave to idle.

Only the bench scenarios can show the memory contents. These cover write-then-read round trips, burst fills that wrap past the last word, and garbage addresses driven during data phases that must not change which words are read. They also confirm that out-of-window writes leave every local word intact.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } ebs_state_e;

  typedef struct packed {
    logic bank0;
    logic bank1;
    logic host;
    logic local_mem;
  } ebs_sel_t;

  // Decode the top TAG_W bits of an address into region flags.
  function automatic ebs_sel_t ebs_decode(input logic [4:0] tag,
                                          input logic [4:0] tag_b0,
                                          input logic [4:0] tag_b1,
                                          input logic [4:0] tag_loc);
    ebs_sel_t s;
    s.bank0     = (tag == tag_b0);
    s.bank1     = (tag == tag_b1);
    s.host      = tag[4];
    s.local_mem = (tag == tag_loc);
    return s;
  endfunction

  // Next word index of a burst; wraps naturally at the index width.
  function automatic logic [7:0] ebs_step(input logic [7:0] idx);
    return idx + 8'd1;
  endfunction

endpackage

// File: rtl/ebs_addr_decode.sv
module ebs_addr_decode #(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 5,
  parameter logic [TAG_W-1:0] TAG_BANK0 = 5'b00110,
  parameter logic [TAG_W-1:0] TAG_BANK1 = 5'b00111,
  parameter logic [TAG_W-1:0] TAG_LOCAL = 5'b00000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output logic              sel_bank0,
  output logic              sel_bank1,
  output logic              sel_host,
  output logic              is_local
);
  import ebs_pkg::*;

  localparam int TAG_LSB = ADDR_W - TAG_W;

  logic [TAG_W-1:0] tag;
  ebs_sel_t         dec;

  assign tag = addr[ADDR_W-1:TAG_LSB];

  always_comb begin
    dec       = ebs_decode(tag, TAG_BANK0, TAG_BANK1, TAG_LOCAL);
    sel_bank0 = strobe & dec.bank0;
    sel_bank1 = strobe & dec.bank1;
    sel_host  = strobe & dec.host;
    is_local  = dec.local_mem;
  end

endmodule

// File: rtl/ebs_wait_timer.sv
module ebs_wait_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              expire
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Last wait cycle of the current beat.
  assign expire = run && (cnt_q == WAIT_W'(1));

endmodule

// File: rtl/ebs_word_mem.sv
module ebs_word_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      words[waddr] <= wdata;
    end
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/ebs_slave.sv
module ebs_slave #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_DEPTH = 256,
  parameter int WAIT_W = 2,
  parameter int TAG_W = 5,
  parameter logic [TAG_W-1:0] TAG_BANK0 = 5'b00110,
  parameter logic [TAG_W-1:0] TAG_BANK1 = 5'b00111,
  parameter logic [TAG_W-1:0] TAG_LOCAL = 5'b00000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_burst,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        wait_cfg,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              sel_bank0,
  output logic              sel_bank1,
  output logic              sel_host
);
  import ebs_pkg::*;

  localparam int IDX_W = $clog2(MEM_DEPTH);

  ebs_state_e        state_q, state_d;
  logic              xfer_rd, xfer_hit;
  logic [IDX_W-1:0]  beat_idx, nxt_idx;
  logic [DATA_W-1:0] rdata_q, mem_rdata;
  logic              ack_q;

  // Named internal events, also used by the bound checker.
  logic strobe, is_local;
  logic start_xfer, start_hit, beat_done, burst_more;
  logic in_wait, in_idle;
  logic need_wait, wait_load, wait_expire;
  logic nxt_rd, nxt_hit, mem_we;

  assign strobe     = bus_rd | bus_wr;
  assign in_idle    = (state_q == ST_IDLE);
  assign in_wait    = (state_q == ST_WAIT);
  assign beat_done  = (state_q == ST_DATA);
  assign start_xfer = in_idle & strobe;
  assign start_hit  = start_xfer & is_local;
  assign burst_more = beat_done & bus_burst;
  assign wait_load  = start_xfer | burst_more;

  ebs_addr_decode #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W),
    .TAG_BANK0(TAG_BANK0), .TAG_BANK1(TAG_BANK1), .TAG_LOCAL(TAG_LOCAL)
  ) u_dec (
    .addr(bus_addr), .strobe(strobe),
    .sel_bank0(sel_bank0), .sel_bank1(sel_bank1), .sel_host(sel_host),
    .is_local(is_local)
  );

  ebs_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .load(wait_load), .load_val(wait_cfg),
    .run(in_wait), .expire(wait_expire)
  );

  ebs_word_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(beat_idx), .wdata(bus_wdata),
    .raddr(nxt_idx), .rdata(mem_rdata)
  );

  // Attributes of the beat about to start.
  always_comb begin
    nxt_hit = start_xfer ? is_local : xfer_hit;
    nxt_rd  = start_xfer ? bus_rd : xfer_rd;
    need_wait = nxt_hit && (wait_cfg != '0);
    if (start_xfer) begin
      nxt_idx = bus_addr[IDX_W-1:0];
    end else if (burst_more) begin
      nxt_idx = IDX_W'(ebs_step(8'(beat_idx)));
    end else begin
      nxt_idx = beat_idx;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (strobe) state_d = need_wait ? ST_WAIT : ST_DATA;
      ST_WAIT: if (wait_expire) state_d = ST_DATA;
      ST_DATA: begin
        if (bus_burst) state_d = need_wait ? ST_WAIT : ST_DATA;
        else           state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_we = beat_done & ~xfer_rd & xfer_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      xfer_rd  <= 1'b0;
      xfer_hit <= 1'b0;
      beat_idx <= '0;
      rdata_q  <= '0;
      ack_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d != ST_WAIT);
      if (start_xfer) begin
        xfer_rd  <= bus_rd;
        xfer_hit <= is_local;
      end
      if (wait_load) begin
        beat_idx <= nxt_idx;
      end
      if (state_d == ST_DATA) begin
        rdata_q <= (nxt_rd && nxt_hit) ? mem_rdata : '0;
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = beat_done ? rdata_q : '0;

endmodule

// File: rtl/ebs_slave_chk.sv
module ebs_slave_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             bus_burst,
  input logic [1:0]       wait_cfg,
  input logic             bus_ack,
  input logic             sel_bank0,
  input logic             sel_bank1,
  input logic             sel_host,
  input logic             start_xfer,
  input logic             start_hit,
  input logic             beat_done,
  input logic             xfer_hit,
  input logic             in_wait,
  input logic             in_idle,
  input logic [IDX_W-1:0] beat_idx
);

  // R2
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_bank0, sel_bank1, sel_host}));

  // R2
  sel_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bank0 || sel_bank1 || sel_host) |-> (bus_rd || bus_wr));

  // R3
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> in_wait);

  // R3
  wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && wait_cfg != 2'd0) |=> !bus_ack);

  // R9
  miss_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_xfer && !start_hit) |=> bus_ack);

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && bus_burst) |=> (beat_idx == $past(beat_idx) + 1'b1));

  // R7
  burst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && bus_burst && xfer_hit && wait_cfg != 2'd0) |=> !bus_ack);

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !bus_burst) |=> in_idle);

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !beat_done) |=> $stable(beat_idx));

endmodule

bind ebs_slave ebs_slave_chk #(.IDX_W(8)) u_chk (.*);

// File: tb/tb_ebs_slave.sv
module tb_ebs_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_burst = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  wait_cfg = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        sel_bank0, sel_bank1, sel_host;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [256];
  logic        known [256];

  always #5 clk = ~clk;

  ebs_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_burst(bus_burst), .bus_wdata(bus_wdata),
    .wait_cfg(wait_cfg), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .sel_bank0(sel_bank0), .sel_bank1(sel_bank1), .sel_host(sel_host)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One transfer of 'beats' beats starting at addr; checks wait timing and data.
  task automatic xfer(input logic [31:0] addr, input bit is_rd, input int w,
                      input int beats, input logic [31:0] wbase, input string req);
    bit         hit = (addr[31:27] == 5'b00000);
    int         ew = hit ? w : 0;
    logic [7:0] idx = addr[7:0];
    logic [31:0] exp;
    bus_addr = addr; bus_rd = is_rd; bus_wr = !is_rd;
    bus_burst = (beats > 1); wait_cfg = w[1:0];
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = addr ^ 32'h0000_005A;   // garbage during data phase, must be ignored
    for (int b = 0; b < beats; b++) begin
      for (int k = 0; k < ew; k++) begin
        check(bus_ack == 1'b0, req, "ack low in wait", {31'd0, bus_ack}, 32'd0);
        @(posedge clk); #1;
      end
      check(bus_ack == 1'b1, req, "ack high on beat", {31'd0, bus_ack}, 32'd1);
      if (is_rd) begin
        exp = (hit && known[idx]) ? model[idx] : 32'd0;
        check(bus_rdata == exp, req, "read data", bus_rdata, exp);
      end else begin
        bus_wdata = wbase + b;
        if (hit) begin model[idx] = wbase + b; known[idx] = 1'b1; end
      end
      if (b == beats - 1) bus_burst = 1'b0;
      @(posedge clk); #1;
      idx = idx + 8'd1;
    end
    check(bus_ack == 1'b1, req, "ack high in idle", {31'd0, bus_ack}, 32'd1);
    check(bus_rdata == 32'd0, req, "rdata zero in idle", bus_rdata, 32'd0);
  endtask

  task automatic t_reset();
    check(bus_ack == 1'b1, "R1", "ack after reset", {31'd0, bus_ack}, 32'd1);
    check({sel_bank0, sel_bank1, sel_host} == 3'b000, "R1", "selects after reset",
          {29'd0, sel_bank0, sel_bank1, sel_host}, 32'd0);
    check(bus_rdata == 32'd0, "R1", "rdata after reset", bus_rdata, 32'd0);
  endtask

  task automatic sel_probe(input logic [31:0] a, input bit rd, input bit wr,
                           input logic [2:0] exp);
    bus_addr = a; bus_rd = rd; bus_wr = wr;
    #1;
    check({sel_bank0, sel_bank1, sel_host} == exp, "R2", "select decode",
          {29'd0, sel_bank0, sel_bank1, sel_host}, {29'd0, exp});
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    #1;
  endtask

  task automatic t_decode();
    sel_probe(32'h3000_0010, 1'b1, 1'b0, 3'b100);   // 00110 -> bank0
    sel_probe(32'h3800_0000, 1'b0, 1'b1, 3'b010);   // 00111 -> bank1
    sel_probe(32'h8000_0004, 1'b1, 1'b0, 3'b001);   // bit31 -> host
    sel_probe(32'hF800_0000, 1'b0, 1'b1, 3'b001);
    sel_probe(32'h3000_0000, 1'b0, 1'b0, 3'b000);   // no strobe
    sel_probe(32'h0000_0001, 1'b1, 1'b0, 3'b000);   // local window
  endtask

  task automatic t_single();
    xfer(32'h0000_0010, 1'b0, 2, 1, 32'hA5A5_0000, "R5");
    xfer(32'h0000_0010, 1'b1, 0, 1, 32'd0, "R4");
    xfer(32'h0000_0011, 1'b0, 0, 1, 32'h1234_5678, "R5");
    xfer(32'h0000_0011, 1'b1, 3, 1, 32'd0, "R3");
    xfer(32'h0000_0010, 1'b1, 1, 1, 32'd0, "R3");
  endtask

  task automatic t_both_strobes();
    // both strobes: behaves as a read, memory unchanged
    bus_addr = 32'h0000_0010; bus_rd = 1'b1; bus_wr = 1'b1; wait_cfg = 2'd0;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 32'hDEAD_BEEF;
    check(bus_rdata == model[8'h10], "R5", "rd priority", bus_rdata, model[8'h10]);
    @(posedge clk); #1;
    xfer(32'h0000_0010, 1'b1, 0, 1, 32'd0, "R5");
  endtask

  task automatic t_burst();
    xfer(32'h0000_0040, 1'b0, 1, 4, 32'hB000_0000, "R6");
    xfer(32'h0000_0040, 1'b1, 3, 4, 32'd0, "R7");
    xfer(32'h0000_00FE, 1'b0, 0, 3, 32'hC000_0000, "R6");
    xfer(32'h0000_00FE, 1'b1, 2, 3, 32'd0, "R6");
    // fresh address after burst end
    xfer(32'h0000_0042, 1'b1, 0, 1, 32'd0, "R8");
    xfer(32'h0000_0011, 1'b1, 1, 1, 32'd0, "R8");
  endtask

  task automatic t_miss();
    xfer(32'h3000_0010, 1'b0, 3, 1, 32'hEEEE_0001, "R9");
    xfer(32'h8000_0041, 1'b0, 2, 2, 32'hEEEE_0002, "R9");
    xfer(32'h3800_0010, 1'b1, 3, 1, 32'd0, "R9");
    xfer(32'h0000_0010, 1'b1, 0, 1, 32'd0, "R9");
    xfer(32'h0000_0041, 1'b1, 0, 2, 32'd0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin model[i] = '0; known[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_decode();
    t_single();
    t_both_strobes();
    t_burst();
    t_miss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule